// File: doc/BRIEF.md
# Multi-Output Receiver Clock Generator

This block runs entirely from one 40 MHz master clock. It produces three clock-like outputs and two single-cycle enable strobes, all as plain registers in the master domain. The first output is a 20 MHz processor clock with an exact 50% duty cycle. The second is a sample clock at one seventh of the master rate, about 5.714 MHz, which is also suitable for driving an external RF front end. The third is a wait-state processor clock whose high phase can be stretched one master cycle at a time, so that slow memory gets extra time.

An active-low system-select input turns the stretching behaviour on. While that input is high, the wait-state clock copies the 20 MHz clock and ignores wait requests. Logic elsewhere in the master domain can use the sample enable strobe and the wait-state rising-edge strobe instead of treating the derived clocks as real clocks.

Top module: `clkgen_top`

## Requirements
- R1: A synchronous active-high reset clears every divider and forces all five outputs low from the first clock edge at which reset is sampled high.
- R2: Outside reset, `proc_clk` inverts at every master edge, so it runs at half the master rate with one master cycle high and one low. It goes high at the first edge after reset is released.
- R3: `samp_clk` has a period of 7 master cycles, with 4 cycles high followed by 3 low. Its first high cycle begins at the first edge after reset is released.
- R4: `samp_en` is high for exactly one master cycle in each sample period, and that cycle is the first high cycle of `samp_clk`.
- R5: When `sys_sel_n` is 1 at an edge, `ws_clk` takes the same value as `proc_clk` after that edge, and `wait_req` has no effect.
- R6: When `sys_sel_n` is 0 and both `ws_clk` and `wait_req` are 1 at an edge, `ws_clk` stays 1 for one more master cycle. Consecutive requests stretch the high phase by one cycle each.
- R7: When `sys_sel_n` is 0, a low `ws_clk` always goes high at the next edge, and a high `ws_clk` with `wait_req` at 0 goes low at the next edge.
- R8: `ws_rise_en` is 1 in exactly those master cycles in which `ws_clk` has just changed from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 40 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_sel_n | input | 1 | Active low: 0 enables the stretchable wait-state clock |
| wait_req | input | 1 | Wait request, sampled while `ws_clk` is high |
| proc_clk | output | 1 | 20 MHz processor clock with 50% duty cycle |
| samp_clk | output | 1 | Master divided by 7 (4 high, 3 low) |
| samp_en | output | 1 | One-cycle strobe at the sample clock rising edge |
| ws_clk | output | 1 | Wait-state processor clock |
| ws_rise_en | output | 1 | One-cycle strobe at the `ws_clk` rising edge |

## Verification
The bench goes after long runs of back-to-back wait requests, and checks that each request adds exactly one cycle. A design that lost a request, or held one too long, would shift every following edge of `ws_clk`. It toggles `sys_sel_n` in the middle of stretched phases and holds `wait_req` high in follow mode. A design that leaked the request into follow mode would fall out of step with `proc_clk`. It also asserts reset in the middle of a sample period and checks that the 4/3 pattern restarts from its first high cycle. A counter that was not cleared would put the first `samp_en` in the wrong cycle.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    // Default divider settings for the sample clock
    localparam int unsigned SAMP_DIV_DEF  = 7;
    localparam int unsigned SAMP_HIGH_DEF = 4;

    // Registered state of the wait-state clock unit
    typedef struct packed {
        logic clk;
        logic rise;
    } ws_state_t;

    // Registered state of the half-rate unit
    typedef struct packed {
        logic clk;
    } half_state_t;

endpackage

// File: rtl/clkgen_half_div.sv
module clkgen_half_div
    import clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic half_clk
);

    half_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.clk = 1'b0;
        end else begin
            st_d.clk = ~st_q.clk;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign half_clk = st_q.clk;

endmodule

// File: rtl/clkgen_frac_div.sv
module clkgen_frac_div #(
    parameter int unsigned DIV  = 7,
    parameter int unsigned HIGH = 4
) (
    input  logic clk,
    input  logic rst,
    output logic div_clk,
    output logic div_en
);

    localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(DIV - 1);
    localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(HIGH);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             clk;
        logic             en;
    } frac_state_t;

    frac_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt = '0;
            st_d.clk = 1'b0;
            st_d.en  = 1'b0;
        end else begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
            st_d.clk = (st_q.cnt < HI_LIM);
            st_d.en  = (st_q.cnt == '0);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign div_clk = st_q.clk;
    assign div_en  = st_q.en;

endmodule

// File: rtl/clkgen_stretch.sv
module clkgen_stretch
    import clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel_n,
    input  logic wait_req,
    input  logic half_clk,
    output logic ws_clk,
    output logic ws_rise
);

    ws_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.clk  = 1'b0;
            st_d.rise = 1'b0;
        end else begin
            if (sel_n) begin
                // follow mode: match the next value of the half-rate clock
                st_d.clk = ~half_clk;
            end else if (st_q.clk && wait_req) begin
                st_d.clk = 1'b1;
            end else begin
                st_d.clk = ~st_q.clk;
            end
            st_d.rise = ~st_q.clk & st_d.clk;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ws_clk  = st_q.clk;
    assign ws_rise = st_q.rise;

endmodule

// File: rtl/clkgen_top.sv
module clkgen_top #(
    parameter int unsigned SAMP_DIV  = clkgen_pkg::SAMP_DIV_DEF,
    parameter int unsigned SAMP_HIGH = clkgen_pkg::SAMP_HIGH_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic sys_sel_n,
    input  logic wait_req,
    output logic proc_clk,
    output logic samp_clk,
    output logic samp_en,
    output logic ws_clk,
    output logic ws_rise_en
);

    logic half_w;

    clkgen_half_div u_half (
        .clk      (clk),
        .rst      (rst),
        .half_clk (half_w)
    );

    clkgen_frac_div #(
        .DIV  (SAMP_DIV),
        .HIGH (SAMP_HIGH)
    ) u_samp (
        .clk     (clk),
        .rst     (rst),
        .div_clk (samp_clk),
        .div_en  (samp_en)
    );

    clkgen_stretch u_ws (
        .clk      (clk),
        .rst      (rst),
        .sel_n    (sys_sel_n),
        .wait_req (wait_req),
        .half_clk (half_w),
        .ws_clk   (ws_clk),
        .ws_rise  (ws_rise_en)
    );

    assign proc_clk = half_w;

endmodule

// File: rtl/clkgen_top_chk.sv
module clkgen_top_chk (
    input logic clk,
    input logic rst,
    input logic sys_sel_n,
    input logic wait_req,
    input logic proc_clk,
    input logic samp_clk,
    input logic samp_en,
    input logic ws_clk,
    input logic ws_rise_en
);

    AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (proc_clk != $past(proc_clk))); // R2

    AST_SEN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        samp_en |=> !samp_en); // R4

    AST_SEN_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
        samp_en |-> samp_clk); // R4

    AST_FOLLOW_MODE: assert property (@(posedge clk) disable iff (rst)
        sys_sel_n |=> (ws_clk == proc_clk)); // R5

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sys_sel_n && ws_clk && wait_req) |=> ws_clk); // R6

    AST_LOW_RISES: assert property (@(posedge clk) disable iff (rst)
        (!sys_sel_n && !ws_clk) |=> ws_clk); // R7

    AST_RISE_HIGH: assert property (@(posedge clk) disable iff (rst)
        ws_rise_en |-> ws_clk); // R8

endmodule

bind clkgen_top clkgen_top_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sys_sel_n  (sys_sel_n),
    .wait_req   (wait_req),
    .proc_clk   (proc_clk),
    .samp_clk   (samp_clk),
    .samp_en    (samp_en),
    .ws_clk     (ws_clk),
    .ws_rise_en (ws_rise_en)
);

// File: tb/clkgen_top_test.sv
module clkgen_top_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sys_sel_n = 1'b1;
    logic wait_req = 1'b0;
    logic proc_clk, samp_clk, samp_en, ws_clk, ws_rise_en;

    int n_run  = 0;
    int n_fail = 0;

    // reference model state
    logic       m_half = 1'b0;
    logic       m_samp = 1'b0;
    logic       m_sen  = 1'b0;
    logic       m_ws   = 1'b0;
    logic       m_rise = 1'b0;
    int         m_cnt  = 0;

    always #2 clk = ~clk;

    clkgen_top uut (
        .clk        (clk),
        .rst        (rst),
        .sys_sel_n  (sys_sel_n),
        .wait_req   (wait_req),
        .proc_clk   (proc_clk),
        .samp_clk   (samp_clk),
        .samp_en    (samp_en),
        .ws_clk     (ws_clk),
        .ws_rise_en (ws_rise_en)
    );

    function automatic logic ws_next(logic ws, logic half, logic sel, logic w);
        if (sel) return ~half;
        if (ws && w) return 1'b1;
        return ~ws;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // advance model by one edge using the inputs applied to it
    task automatic model_edge();
        logic nws;
        if (rst) begin
            m_half = 0; m_samp = 0; m_sen = 0; m_ws = 0; m_rise = 0; m_cnt = 0;
        end else begin
            nws    = ws_next(m_ws, m_half, sys_sel_n, wait_req);
            m_rise = ~m_ws & nws;
            m_ws   = nws;
            m_half = ~m_half;
            m_samp = (m_cnt < 4);
            m_sen  = (m_cnt == 0);
            m_cnt  = (m_cnt == 6) ? 0 : m_cnt + 1;
        end
    endtask

    task automatic step(logic r, logic sel, logic w);
        logic was_rst;
        rst = r; sys_sel_n = sel; wait_req = w;
        was_rst = r;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (was_rst) begin
            check("R1 proc_clk", proc_clk, 1'b0);
            check("R1 samp_clk", samp_clk, 1'b0);
            check("R1 samp_en", samp_en, 1'b0);
            check("R1 ws_clk", ws_clk, 1'b0);
            check("R1 ws_rise_en", ws_rise_en, 1'b0);
        end else begin
            check("R2 proc_clk", proc_clk, m_half);
            check("R3 samp_clk", samp_clk, m_samp);
            check("R4 samp_en", samp_en, m_sen);
            check(sel ? "R5 ws_clk" : (w ? "R6 ws_clk" : "R7 ws_clk"), ws_clk, m_ws);
            check("R8 ws_rise_en", ws_rise_en, m_rise);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5a17);
        @(negedge clk);
        // R1: reset with assorted inputs
        for (int i = 0; i < 4; i++) step(1'b1, i[0], i[1]);
        // R2 R3 R4: first cycles after release, follow mode
        for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 1'b0);
        // R5: wait request held high in follow mode must be ignored
        for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 1'b1);
        // R6: long run of back-to-back wait requests in stretch mode
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 1'b1);
        // R7: no waits in stretch mode
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b0);
        // R5: mode switch in the middle of a stretched phase
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b0);
        // R1 R3: reset in the middle of a sample period
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 9; i++) step(1'b0, 1'b0, 1'b0);
        // constrained random mix
        begin
            logic sel;
            sel = 1'b0;
            for (int i = 0; i < 4000; i++) begin
                if (($urandom % 16) == 0) sel = ~sel;
                step((($urandom % 300) == 0), sel, $urandom % 2 == 0);
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule